// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a small synthesizable model of a pipelined synchronous burst SRAM. It stores 32-bit words made of four byte lanes. Every control and address input is sampled on the rising clock. An access is opened by one of two address strobes. The processor strobe is honoured only while the first chip select is active. The controller strobe is always honoured.

Once a burst is open, cycles with neither strobe asserted continue it. With the advance input low, a two-bit sequencer steps the word offset in linear or XOR order and wraps within the aligned group of four. With the advance input high, the burst holds its current address. On each cycle the write controls decide between a read and a write. A global write stores all four bytes. A byte write stores only the selected lanes.

Read data passes through an output register and appears one cycle after the address edge. The shared data pins are modelled as a separate input, output and output-enable. The output enable is raised only for a valid read while the asynchronous output enable is low.

Top module: `sync_burst_sram`

## Requirements
- R1: A read starts at an edge where a strobe is honoured, all three chip selects are active (cs1_ni=0, cs2_i=1, cs3_ni=0) and both all_wr_ni and byte_wr_en_ni are high. Its word appears on dq_o with dq_oe_o=1 during the cycle after the next edge, provided out_en_ni is low.
- R2: When cs1_ni is high, the processor strobe is ignored. It neither opens nor deselects an access, and an open burst continues at its held address.
- R3: dq_oe_o is 0 whenever out_en_ni is high, and it is 0 after reset.
- R4: In the first cycle after an access opens from the deselected state, dq_oe_o is 0 even with out_en_ni low.
- R5: A honoured strobe while any chip select is inactive deselects the device. dq_oe_o is 0 in the cycle that follows that edge.
- R6: A processor-strobe write takes two edges. At the first edge, all_wr_ni, byte_wr_en_ni, byte_sel_ni and burst_adv_ni are ignored. The write occurs at the second edge (no strobe, burst_adv_ni high), using the write controls and dq_i present at that edge.
- R7: all_wr_ni low writes all four bytes, whatever byte_wr_en_ni and byte_sel_ni are.
- R8: With all_wr_ni high and byte_wr_en_ni low, byte lane k (bits 8k+7..8k) is written only if byte_sel_ni[k] is 0. Unselected lanes keep their contents.
- R9: Reads started on consecutive edges return their words on consecutive cycles.
- R10: With burst_mode_i=0 (linear) and start address S, beat j uses address {S[5:2], (S[1:0]+j) mod 4}.
- R11: With burst_mode_i=1 (XOR order), beat j uses address {S[5:2], S[1:0] xor j}.
- R12: A continuation cycle with burst_adv_ni high repeats the current address. The two-bit counter wraps from 3 to 0.
- R13: A controller-strobe write stores dq_i at addr_i on the same edge, under the controls of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_strb_ni | input | 1 | Processor address strobe, active low |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| burst_adv_ni | input | 1 | Burst advance, active low |
| cs1_ni | input | 1 | Chip select 1, active low, also gates the processor strobe |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| all_wr_ni | input | 1 | Global write of all bytes, active low |
| byte_wr_en_ni | input | 1 | Byte write enable, active low |
| byte_sel_ni | input | 4 | Per-lane byte select, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| burst_mode_i | input | 1 | Burst order: 0 linear, 1 XOR |
| addr_i | input | 6 | Word address |
| dq_i | input | 32 | Write data from the shared pins |
| dq_o | output | 32 | Read data from the output register |
| dq_oe_o | output | 1 | Drive enable for the shared pins |

## Verification
The interesting collision is a processor strobe that arrives while the first chip select is high and a burst is already open. In that cycle the ignored strobe and the burst continuation land on the same edge. The bench opens a burst at one address, then presents the blocked strobe with a different address. It judges the outcome by the word returned two cycles later, which must still come from the held address. The same sweep also presents the blocked strobe from the deselected state, where the output must stay undriven.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    BURST_LINEAR = 1'b0,
    BURST_XOR    = 1'b1
  } burst_mode_e;

  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input burst_mode_e mode);
    return (mode == BURST_XOR) ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  burst_mode_e       mode_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;

  assign cnt_nxt = cnt_q + 2'd1;
  assign cur_o   = {base_q[ADDR_W-1:CNT_W], beat_offset(base_q[CNT_W-1:0], cnt_q, mode_i)};
  assign nxt_o   = {base_q[ADDR_W-1:CNT_W], beat_offset(base_q[CNT_W-1:0], cnt_nxt, mode_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= start_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_BURST_STARTS_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_o == $past(start_i)); // R1
  AST_BURST_GROUP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> cur_o[ADDR_W-1:CNT_W] == $past(cur_o[ADDR_W-1:CNT_W])); // R12
  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_i == BURST_LINEAR) |=>
      (mode_i != BURST_LINEAR) || (cur_o[CNT_W-1:0] == $past(cur_o[CNT_W-1:0]) + 2'd1)); // R10
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    proc_strb_ni,
  input  logic                    ctrl_strb_ni,
  input  logic                    burst_adv_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    all_wr_ni,
  input  logic                    byte_wr_en_ni,
  input  logic [LANES-1:0]        byte_sel_ni,
  input  logic                    out_en_ni,
  input  logic                    burst_mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              chip_sel, proc_go, ctrl_go, wr_req;
  logic              load, advance, desel, do_rd, do_wr;
  logic [LANES-1:0]  wr_mask, we_mask;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, acc_addr, rd_addr_q;
  logic [DATA_W-1:0] rd_word, dout_q;
  logic              active_q, rd_pend_q, out_vld_q;

  assign chip_sel = !cs1_ni && cs2_i && !cs3_ni;
  assign proc_go  = !proc_strb_ni && !cs1_ni;  // processor strobe gated by cs1
  assign ctrl_go  = !ctrl_strb_ni;
  assign wr_req   = !all_wr_ni || !byte_wr_en_ni;
  assign wr_mask  = !all_wr_ni     ? {LANES{1'b1}} :
                    !byte_wr_en_ni ? ~byte_sel_ni  : {LANES{1'b0}};

  always_comb begin
    load     = 1'b0;
    advance  = 1'b0;
    desel    = 1'b0;
    do_rd    = 1'b0;
    do_wr    = 1'b0;
    acc_addr = cur_addr;
    if (proc_go) begin
      // write controls ignored here; a write follows as a continuation
      if (chip_sel) begin
        load     = 1'b1;
        do_rd    = 1'b1;
        acc_addr = addr_i;
      end else begin
        desel    = 1'b1;
      end
    end else if (ctrl_go) begin
      if (chip_sel) begin
        load     = 1'b1;
        acc_addr = addr_i;
        do_wr    = wr_req;
        do_rd    = !wr_req;
      end else begin
        desel    = 1'b1;
      end
    end else if (active_q) begin
      advance  = !burst_adv_ni;
      acc_addr = advance ? nxt_addr : cur_addr;
      do_wr    = wr_req;
      do_rd    = !wr_req;
    end
  end

  assign we_mask = do_wr ? wr_mask : {LANES{1'b0}};

  sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .adv_i   (advance),
    .start_i (addr_i),
    .mode_i  (burst_mode_e'(burst_mode_i)),
    .cur_o   (cur_addr),
    .nxt_o   (nxt_addr)
  );

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (we_mask),
    .waddr_i (acc_addr),
    .wdata_i (dq_i),
    .raddr_i (rd_addr_q),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      out_vld_q <= 1'b0;
      dout_q    <= '0;
    end else begin
      if (desel)     active_q <= 1'b0;
      else if (load) active_q <= 1'b1;
      rd_pend_q <= do_rd;
      if (do_rd) rd_addr_q <= acc_addr;
      out_vld_q <= rd_pend_q && !desel && !do_wr;
      if (rd_pend_q) dout_q <= rd_word;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = out_vld_q && !out_en_ni;

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |=> !dq_oe_o); // R5
  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !active_q) |=> !dq_oe_o); // R4
  AST_PROC_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs1_ni && ctrl_strb_ni && !active_q) |=> !active_q); // R2
  AST_PROC_FIRST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni && chip_sel) |-> we_mask == '0); // R6
endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        proc_strb_ni, ctrl_strb_ni, burst_adv_ni;
  logic        cs1_ni, cs2_i, cs3_ni;
  logic        all_wr_ni, byte_wr_en_ni;
  logic [3:0]  byte_sel_ni;
  logic        out_en_ni, burst_mode_i;
  logic [AW-1:0] addr_i;
  logic [31:0] dq_i, dq_o;
  logic        dq_oe_o;

  logic [31:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sync_burst_sram u_sync_burst_sram (
    .clk_i, .rst_ni, .proc_strb_ni, .ctrl_strb_ni, .burst_adv_ni,
    .cs1_ni, .cs2_i, .cs3_ni, .all_wr_ni, .byte_wr_en_ni, .byte_sel_ni,
    .out_en_ni, .burst_mode_i, .addr_i, .dq_i, .dq_o, .dq_oe_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic quiet();
    proc_strb_ni = 1'b1; ctrl_strb_ni = 1'b1; burst_adv_ni = 1'b1;
    cs1_ni = 1'b0; cs2_i = 1'b1; cs3_ni = 1'b0;
    all_wr_ni = 1'b1; byte_wr_en_ni = 1'b1; byte_sel_ni = 4'hF;
    addr_i = '0; dq_i = '0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = m[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
    return r;
  endfunction

  task automatic ctrl_write(input int a, input logic gw_n, input logic bwe_n, input logic [3:0] sel_n, input logic [31:0] d);
    quiet(); out_en_ni = 1'b1;
    ctrl_strb_ni = 1'b0; addr_i = AW'(a);
    all_wr_ni = gw_n; byte_wr_en_ni = bwe_n; byte_sel_ni = sel_n; dq_i = d;
    step();
    if (!gw_n) ref_mem[a] = d;
    else if (!bwe_n) ref_mem[a] = merge(ref_mem[a], d, ~sel_n);
  endtask

  task automatic read_check(input int a, input string req);
    quiet(); out_en_ni = 1'b0; ctrl_strb_ni = 1'b0; addr_i = AW'(a);
    step();
    quiet();
    step();
    chk(dq_oe_o && dq_o == ref_mem[a], req, dq_o, ref_mem[a]);
    out_en_ni = 1'b1;
  endtask

  task automatic deselect();
    quiet(); ctrl_strb_ni = 1'b0; cs2_i = 1'b0;
    step();
    quiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    quiet(); out_en_ni = 1'b0; burst_mode_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!dq_oe_o, "R3 reset", {31'd0, dq_oe_o}, 32'd0);
    rst_ni = 1'b1;
    step();
    chk(!dq_oe_o, "R3 idle", {31'd0, dq_oe_o}, 32'd0);

    // R13: fill with controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) ctrl_write(a, 1'b0, 1'b1, 4'hF, (a + 1) * 32'h9E37_79B9);
    deselect();

    // R1 R9 R4: back-to-back reads over every address
    for (int a = 0; a < DEPTH; a++) begin
      quiet(); out_en_ni = 1'b0; ctrl_strb_ni = 1'b0; addr_i = AW'(a);
      step();
      if (a == 0) chk(!dq_oe_o, "R4 first cycle", {31'd0, dq_oe_o}, 32'd0);
      else chk(dq_oe_o && dq_o == ref_mem[a-1], "R9 R1 read", dq_o, ref_mem[a-1]);
    end
    quiet(); out_en_ni = 1'b0;
    step();
    chk(dq_oe_o && dq_o == ref_mem[DEPTH-1], "R1 last", dq_o, ref_mem[DEPTH-1]);
    out_en_ni = 1'b1;
    step();
    chk(!dq_oe_o, "R3 oe high", {31'd0, dq_oe_o}, 32'd0);
    quiet(); out_en_ni = 1'b0; ctrl_strb_ni = 1'b0; cs3_ni = 1'b1;
    step();
    chk(!dq_oe_o, "R5 deselect cs3", {31'd0, dq_oe_o}, 32'd0);
    quiet();
    step();
    chk(!dq_oe_o, "R5 stays off", {31'd0, dq_oe_o}, 32'd0);
    // processor strobe with cs1 low but cs2 inactive also deselects
    read_check(3, "R1 reopen");
    quiet(); out_en_ni = 1'b0; proc_strb_ni = 1'b0; cs2_i = 1'b0;
    step();
    chk(!dq_oe_o, "R5 proc deselect", {31'd0, dq_oe_o}, 32'd0);
    out_en_ni = 1'b1;

    // R8 R7: every byte-select pattern, with and without global write
    for (int m = 0; m < 16; m++) ctrl_write(16 + m, 1'b1, 1'b0, ~4'(m), ~ref_mem[16 + m]);
    for (int m = 0; m < 16; m++) ctrl_write(32 + m, 1'b0, m[0], ~4'(m), ref_mem[32 + m] ^ 32'h5A5A_A5A5);
    for (int m = 0; m < 16; m++) read_check(16 + m, "R8 byte lanes");
    for (int m = 0; m < 16; m++) read_check(32 + m, "R7 global override");

    // R6: processor-strobe writes
    quiet(); out_en_ni = 1'b1; proc_strb_ni = 1'b0; addr_i = 6'd50;
    all_wr_ni = 1'b0; byte_wr_en_ni = 1'b0; byte_sel_ni = 4'h0; burst_adv_ni = 1'b0; dq_i = 32'hDEAD_BEEF;
    step();
    quiet(); byte_wr_en_ni = 1'b0; byte_sel_ni = 4'b1110; dq_i = 32'h1234_5678;
    step();
    ref_mem[50] = merge(ref_mem[50], 32'h1234_5678, 4'b0001);
    read_check(50, "R6 byte write on second edge");
    quiet(); out_en_ni = 1'b1; proc_strb_ni = 1'b0; addr_i = 6'd51; dq_i = 32'hFFFF_FFFF;
    step();
    quiet(); all_wr_ni = 1'b0; dq_i = 32'hCAFE_F00D;
    step();
    ref_mem[51] = 32'hCAFE_F00D;
    read_check(51, "R6 global write on second edge");

    // R2: blocked processor strobe during an open burst
    quiet(); out_en_ni = 1'b0; ctrl_strb_ni = 1'b0; addr_i = 6'd5;
    step();
    quiet(); proc_strb_ni = 1'b0; cs1_ni = 1'b1; addr_i = 6'd6;
    step();
    chk(dq_oe_o && dq_o == ref_mem[5], "R2 burst read", dq_o, ref_mem[5]);
    quiet();
    step();
    chk(dq_oe_o && dq_o == ref_mem[5], "R2 strobe ignored", dq_o, ref_mem[5]);
    deselect(); out_en_ni = 1'b0;
    proc_strb_ni = 1'b0; cs1_ni = 1'b1; addr_i = 6'd7;
    step();
    quiet();
    step(); step();
    chk(!dq_oe_o, "R2 no access opened", {31'd0, dq_oe_o}, 32'd0);

    // R10 R11 R12: bursts in both orders from every start offset
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        int bt [4];
        for (int j = 0; j < 4; j++) bt[j] = 8 + (md == 1 ? (s ^ j) : ((s + j) % 4));
        burst_mode_i = md[0];
        quiet(); out_en_ni = 1'b0; ctrl_strb_ni = 1'b0; addr_i = AW'(8 + s);
        step();
        for (int j = 1; j < 4; j++) begin
          quiet(); burst_adv_ni = 1'b0;
          step();
          chk(dq_oe_o && dq_o == ref_mem[bt[j-1]], md == 1 ? "R11 xor beat" : "R10 linear beat", dq_o, ref_mem[bt[j-1]]);
        end
        quiet();
        step();
        chk(dq_o == ref_mem[bt[3]], md == 1 ? "R11 last beat" : "R10 last beat", dq_o, ref_mem[bt[3]]);
        step();
        chk(dq_o == ref_mem[bt[3]], "R12 hold", dq_o, ref_mem[bt[3]]);
        burst_adv_ni = 1'b0;
        step();
        burst_adv_ni = 1'b1;
        step();
        chk(dq_o == ref_mem[bt[0]], "R12 wrap", dq_o, ref_mem[bt[0]]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule